// File: doc/BRIEF.md
# Bit Rotate, Shift and Nibble Rotate Unit

This block is the bit-movement datapath of an 8-bit processor core. It takes a byte operand, a carry bit and a flag byte. It returns the byte after a rotate or a shift, together with the next flag byte. Two further operations move 4-bit digits around a 12-bit ring made of the low digit of the accumulator and both digits of a memory byte. Those two produce a new accumulator and a new memory byte in the same cycle.

A mode input picks the short accumulator form of the four rotates. In that form only the carry flag is rewritten and every other flag passes through. In the full form all flags are rewritten and parity is reported. The unit computes its results combinationally and registers them, so results appear one clock after the inputs are presented. Flag bit positions are: 7 sign, 6 zero, 4 half-carry, 2 parity/overflow, 1 subtract, 0 carry. Bits 5 and 3 are not used.

Top module: `rot_shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_out`, `mem_out` and `flags_out` become 0x00. Otherwise every output shows, one rising edge later, the function of the inputs presented before that edge.
- R2: Circular rotates: code 0 moves bit 7 into both carry and bit 0 (0x95 gives 0x2B, carry 1). Code 1 mirrors this, moving bit 0 into both carry and bit 7 (0x95 gives 0xCA, carry 1).
- R3: Rotates through carry: code 2 shifts left, sends bit 7 to carry and fills bit 0 with the old carry (`flags_in` bit 0); 0x95 with carry 0 gives 0x2A, carry 1. Code 3 is the right-hand mirror.
- R4: Code 4 shifts left and fills bit 0 with zero. Code 6 shifts right and fills bit 7 with zero. In both, the bit shifted out goes to carry.
- R5: Code 5 shifts right, keeps bit 7 and sends bit 0 to carry (0xFC gives 0xFE, carry 0).
- R6: Full-form flags for codes 0 to 6: sign is result bit 7; zero is set when the result is 0; parity/overflow is 1 when the result has an even count of ones; half-carry, subtract and bits 5 and 3 are 0; carry is as in R2 to R5.
- R7: With `short_mode` = 1, codes 0 to 3 still produce the R2/R3 result and carry, but flag bits 7 to 1 equal `flags_in` bits 7 to 1.
- R8: `short_mode` has no effect on codes 4 to 6, 8 and 9.
- R9: Code 8 (digit rotate left) rotates the digits left around the ring. The accumulator's high digit is untouched. A=0x25, M=0xEB gives A=0x2E, M=0xB5.
- R10: Code 9 (digit rotate right) takes A=0x25, M=0xEB to A=0x2B, M=0x5E. Applying it twice gives the same result as code 8 once.
- R11: For codes 8 and 9, sign, zero and parity come from the new accumulator, half-carry, subtract and bits 5 and 3 are 0, and carry equals `flags_in` bit 0.
- R12: Any other code (7, 10 to 15) passes through: `res_out` = `operand` and `flags_out` = `flags_in`.
- R13: For every code other than 8 and 9, `mem_out` = `mem_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Operation select (codes in R2 to R12) |
| short_mode | input | 1 | 1 selects the carry-only accumulator rotate form |
| operand | input | 8 | Byte to rotate or shift |
| acc_in | input | 8 | Accumulator for digit rotates |
| mem_in | input | 8 | Memory byte for digit rotates |
| flags_in | input | 8 | Current flag byte; bit 0 is carry-in |
| res_out | output | 8 | Shifted byte, or new accumulator for codes 8 and 9 |
| mem_out | output | 8 | New memory byte |
| flags_out | output | 8 | Next flag byte |

## Verification
The bench builds the unit with its default 8-bit data width, the only width whose digit ring matches the worked values in R9 and R10. With that width it can reach the edge patterns: a shift that empties the byte and sets zero and parity together, and a sign bit that a right rotate or shift carries in from bit 7 or from the old carry. Under the same width it also covers the short rotate form against a busy incoming flag byte, two digit rotates in a row, and the pass-through codes.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int FLAG_W  = 8;
  localparam int OP_W    = 4;
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  localparam logic [OP_W-1:0] OP_ROL_CIRC  = 4'd0;
  localparam logic [OP_W-1:0] OP_ROR_CIRC  = 4'd1;
  localparam logic [OP_W-1:0] OP_ROL_THRU  = 4'd2;
  localparam logic [OP_W-1:0] OP_ROR_THRU  = 4'd3;
  localparam logic [OP_W-1:0] OP_SHL_ARITH = 4'd4;
  localparam logic [OP_W-1:0] OP_SHR_ARITH = 4'd5;
  localparam logic [OP_W-1:0] OP_SHR_LOGIC = 4'd6;
  localparam logic [OP_W-1:0] OP_DIG_LEFT  = 4'd8;
  localparam logic [OP_W-1:0] OP_DIG_RIGHT = 4'd9;
endpackage

// File: rtl/rsu_shifter.sv
module rsu_shifter
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   din,
  input  logic            cin,
  output logic [DW-1:0]   dout,
  output logic            cout,
  output logic            hit
);
  localparam int MSB = DW - 1;

  always_comb begin
    dout = din;
    cout = cin;
    hit  = 1'b1;
    case (op)
      OP_ROL_CIRC:  begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
      OP_ROR_CIRC:  begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
      OP_ROL_THRU:  begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
      OP_ROR_THRU:  begin dout = {cin, din[MSB:1]};        cout = din[0];   end
      OP_SHL_ARITH: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
      OP_SHR_ARITH: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
      OP_SHR_LOGIC: begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rsu_digit.sv
module rsu_digit
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   mem,
  output logic [DW-1:0]   acc_new,
  output logic [DW-1:0]   mem_new,
  output logic            hit
);
  localparam int NW = DW / 2;

  logic [NW-1:0] a_hi, a_lo, m_hi, m_lo;
  assign a_hi = acc[DW-1:NW];
  assign a_lo = acc[NW-1:0];
  assign m_hi = mem[DW-1:NW];
  assign m_lo = mem[NW-1:0];

  always_comb begin
    acc_new = acc;
    mem_new = mem;
    hit     = 1'b1;
    case (op)
      OP_DIG_LEFT: begin
        acc_new = {a_hi, m_hi};
        mem_new = {m_lo, a_lo};
      end
      OP_DIG_RIGHT: begin
        acc_new = {a_hi, m_lo};
        mem_new = {a_lo, m_hi};
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rsu_flags.sv
module rsu_flags
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     value,
  input  logic              carry,
  input  logic              keep_others,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    if (keep_others) begin
      flags         = flags_in;
      flags[FLAG_C] = carry;
    end else begin
      flags          = '0;
      flags[FLAG_S]  = value[DW-1];
      flags[FLAG_Z]  = (value == '0);
      flags[FLAG_PV] = ~^value;
      flags[FLAG_C]  = carry;
    end
  end
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_code,
  input  logic              short_mode,
  input  logic [DW-1:0]     operand,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     mem_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DW-1:0]     res_out,
  output logic [DW-1:0]     mem_out,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int NW = DW / 2;

  logic [DW-1:0]     sh_val, dg_acc, dg_mem;
  logic              sh_c, sh_hit, dg_hit;
  logic [DW-1:0]     fl_val;
  logic              fl_c, fl_keep;
  logic [FLAG_W-1:0] fl_out;
  logic [DW-1:0]     res_d, mem_d;
  logic [FLAG_W-1:0] flags_d;
  logic              is_rotate;

  rsu_shifter #(.DW(DW)) u_shift (
    .op(op_code), .din(operand), .cin(flags_in[FLAG_C]),
    .dout(sh_val), .cout(sh_c), .hit(sh_hit)
  );

  rsu_digit #(.DW(DW)) u_digit (
    .op(op_code), .acc(acc_in), .mem(mem_in),
    .acc_new(dg_acc), .mem_new(dg_mem), .hit(dg_hit)
  );

  assign is_rotate = (op_code <= OP_ROR_THRU);

  always_comb begin
    if (dg_hit) begin
      fl_val  = dg_acc;
      fl_c    = flags_in[FLAG_C];
      fl_keep = 1'b0;
    end else begin
      fl_val  = sh_val;
      fl_c    = sh_c;
      fl_keep = short_mode && is_rotate;
    end
  end

  rsu_flags #(.DW(DW)) u_flags (
    .value(fl_val), .carry(fl_c), .keep_others(fl_keep),
    .flags_in(flags_in), .flags(fl_out)
  );

  always_comb begin
    if (dg_hit) begin
      res_d   = dg_acc;
      mem_d   = dg_mem;
      flags_d = fl_out;
    end else if (sh_hit) begin
      res_d   = sh_val;
      mem_d   = mem_in;
      flags_d = fl_out;
    end else begin
      res_d   = operand;
      mem_d   = mem_in;
      flags_d = flags_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      mem_out   <= '0;
      flags_out <= '0;
    end else begin
      res_out   <= res_d;
      mem_out   <= mem_d;
      flags_out <= flags_d;
    end
  end

  // R7
  short_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rotate && short_mode) |=> (flags_out[FLAG_W-1:1] == $past(flags_in[FLAG_W-1:1])));

  // R6
  hn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((sh_hit && !(short_mode && is_rotate)) || dg_hit) |=> (!flags_out[FLAG_H] && !flags_out[FLAG_N]));

  // R9
  dig_high_chk: assert property (@(posedge clk) disable iff (rst)
    dg_hit |=> (res_out[DW-1:NW] == $past(acc_in[DW-1:NW])));

  // R11
  dig_carry_chk: assert property (@(posedge clk) disable iff (rst)
    dg_hit |=> (flags_out[FLAG_C] == $past(flags_in[FLAG_C])));

  // R13
  mem_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !dg_hit |=> (mem_out == $past(mem_in)));

  // R12
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (!dg_hit && !sh_hit) |=> (res_out == $past(operand) && flags_out == $past(flags_in)));
endmodule

// File: tb/rot_shift_unit_test.sv
module rot_shift_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = '0;
  logic       short_mode = 1'b0;
  logic [7:0] operand = '0, acc_in = '0, mem_in = '0, flags_in = '0;
  logic [7:0] res_out, mem_out, flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] q_res[$];
  logic [7:0] q_mem[$];
  logic [7:0] q_flg[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  rot_shift_unit uut (
    .clk(clk), .rst(rst), .op_code(op_code), .short_mode(short_mode),
    .operand(operand), .acc_in(acc_in), .mem_in(mem_in), .flags_in(flags_in),
    .res_out(res_out), .mem_out(mem_out), .flags_out(flags_out)
  );

  task automatic drive(input logic [3:0] op, input logic sm, input logic [7:0] opd,
                       input logic [7:0] a, input logic [7:0] m, input logic [7:0] f,
                       input logic [7:0] e_res, input logic [7:0] e_mem,
                       input logic [7:0] e_flg, input string tag);
    @(negedge clk);
    op_code = op; short_mode = sm; operand = opd;
    acc_in = a; mem_in = m; flags_in = f;
    q_res.push_back(e_res); q_mem.push_back(e_mem);
    q_flg.push_back(e_flg); q_tag.push_back(tag);
  endtask

  // monitor: compares one result 1 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q_res.size() > 0) begin
        logic [7:0] er, em, ef;
        string t;
        er = q_res.pop_front(); em = q_mem.pop_front();
        ef = q_flg.pop_front(); t = q_tag.pop_front();
        checks++;
        if (res_out !== er || mem_out !== em || flags_out !== ef) begin
          fails++;
          $display("FAIL %s: got res=%h mem=%h flg=%h, expected res=%h mem=%h flg=%h",
                   t, res_out, mem_out, flags_out, er, em, ef);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (res_out !== 8'h00 || mem_out !== 8'h00 || flags_out !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: got %h %h %h, expected 00 00 00", res_out, mem_out, flags_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2 R6 circular rotates, full form
    drive(4'd0, 0, 8'h95, 8'h00, 8'h11, 8'h00, 8'h2B, 8'h11, 8'h05, "R2/R6 rol circ");
    drive(4'd1, 0, 8'h95, 8'h00, 8'h22, 8'h00, 8'hCA, 8'h22, 8'h85, "R2/R6 ror circ");
    // R3 through carry
    drive(4'd2, 0, 8'h95, 8'h00, 8'h33, 8'h00, 8'h2A, 8'h33, 8'h01, "R3 rol thru c0");
    drive(4'd3, 0, 8'h95, 8'h00, 8'h44, 8'h00, 8'h4A, 8'h44, 8'h01, "R3 ror thru c0");
    drive(4'd3, 0, 8'h95, 8'h00, 8'h44, 8'h01, 8'hCA, 8'h44, 8'h85, "R3 ror thru c1");
    drive(4'd2, 0, 8'h00, 8'h00, 8'h44, 8'h01, 8'h01, 8'h44, 8'h00, "R3 rol thru carry-in fill");
    // R4 zero-fill shifts, R6 zero/parity
    drive(4'd4, 0, 8'h95, 8'h00, 8'h55, 8'hFF, 8'h2A, 8'h55, 8'h01, "R4 shl arith");
    drive(4'd4, 0, 8'h80, 8'h00, 8'h55, 8'h00, 8'h00, 8'h55, 8'h45, "R4/R6 shl to zero");
    drive(4'd6, 0, 8'h81, 8'h00, 8'h66, 8'h00, 8'h40, 8'h66, 8'h01, "R4 shr logic");
    drive(4'd6, 0, 8'h01, 8'h00, 8'h66, 8'h00, 8'h00, 8'h66, 8'h45, "R4/R6 shr to zero");
    // R5 arithmetic right
    drive(4'd5, 0, 8'hFC, 8'h00, 8'h77, 8'h01, 8'hFE, 8'h77, 8'h80, "R5 shr arith");
    // R7 short form keeps other flags
    drive(4'd0, 1, 8'h95, 8'h00, 8'h88, 8'hD6, 8'h2B, 8'h88, 8'hD7, "R7 short rol circ");
    drive(4'd3, 1, 8'h01, 8'h00, 8'h88, 8'hFF, 8'h80, 8'h88, 8'hFF, "R7 short ror thru");
    drive(4'd2, 1, 8'h00, 8'h00, 8'h88, 8'hF7, 8'h01, 8'h88, 8'hF6, "R7 short rol thru carry");
    // R8 short_mode ignored elsewhere
    drive(4'd4, 1, 8'h80, 8'h00, 8'h99, 8'hBA, 8'h00, 8'h99, 8'h45, "R8 short on shl");
    drive(4'd8, 1, 8'h00, 8'h25, 8'hEB, 8'hD6, 8'h2E, 8'hB5, 8'h04, "R8 short on digit left");
    // R9 R10 R11 digit rotates
    drive(4'd8, 0, 8'h00, 8'h25, 8'hEB, 8'h01, 8'h2E, 8'hB5, 8'h05, "R9/R11 digit left");
    drive(4'd9, 0, 8'h00, 8'h25, 8'hEB, 8'h00, 8'h2B, 8'h5E, 8'h04, "R10/R11 digit right");
    drive(4'd9, 0, 8'h00, 8'h2B, 8'h5E, 8'h01, 8'h2E, 8'hB5, 8'h05, "R10 second digit right");
    drive(4'd8, 0, 8'h00, 8'h00, 8'h00, 8'hFE, 8'h00, 8'h00, 8'h44, "R11 digit zero");
    drive(4'd8, 0, 8'h00, 8'h80, 8'h12, 8'h00, 8'h81, 8'h20, 8'h84, "R11 digit sign");
    // R12 R13 pass-through codes
    drive(4'd7,  0, 8'h5A, 8'h00, 8'hC3, 8'h93, 8'h5A, 8'hC3, 8'h93, "R12/R13 code 7");
    drive(4'd15, 1, 8'hA5, 8'h12, 8'h3C, 8'h6E, 8'hA5, 8'h3C, 8'h6E, "R12/R13 code 15");

    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    if (q_res.size() != 0) begin
      fails++;
      $display("FAIL monitor: %0d results never compared, expected 0", q_res.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule